// File: doc/BRIEF.md
# Hash/Cipher Block-Fetch Bus Master

This block feeds a hash or block-cipher engine straight from memory, so the processor does not have to copy each data word into an input register. Software programs a word address, a block count and an enable bit through a small register port. The controller then reads 32-bit words over a request/grant memory bus and packs them into blocks. It hands each block to the engine over a valid/ready stream. The count register counts down as blocks are accepted, and software can read its current value at any time.

In hash mode every block has 16 words. In cipher mode every block has 4 words, except the first one, which can carry key and IV words in front of the data. A 2-bit selector sets the length of that first block. A bus error stops the run at once. The count then keeps the index of the block that failed, and a sticky error flag is set.

Stream rules: `blk_valid` stays high, and `blk_data`/`blk_words` stay stable, until `blk_ready` is high on a clock edge. No memory read is issued while a block waits for acceptance. Back-pressure from the engine therefore stalls memory traffic directly.

Top module: `hcf_fetch_master`

## Requirements
- R1: After reset, every register reads 0 (control at select 0, address at select 1, status at select 2), and `mem_req`, `blk_valid` and all three interrupts are low.
- R2: A run starts only when control is written while idle with enable (bit 0) set and a nonzero count (bits 26:16). A write with count 0, or with enable clear, stores the fields but issues no read.
- R3: Reads begin at the programmed address with bits 1:0 forced to 0, and the address steps by 4 after each granted read. `mem_req` and `mem_addr` stay stable until `mem_gnt`.
- R4: In hash mode (`cipher_mode`=0) a block is 16 words, and `blk_words` reads 16. The k-th word read for a block sits at `blk_data[32k+31:32k]`.
- R5: In cipher mode the first block holds 4, 8 or 12 words for `first_len_sel` 0, 1 or 2, and a value of 3 is treated as 12. Every later block holds 4 words.
- R6: A presented block keeps valid high and its data stable until ready. `mem_req` stays low while valid is high.
- R7: The count decreases by one on each accepted block and reads back live. When the last block is accepted the run ends with the count at 0 and enable cleared.
- R8: In hash mode `irq_digest` pulses for one cycle after the last block is accepted, and `irq_block` stays low.
- R9: In cipher mode `irq_block` pulses for one cycle after every accepted block, and `irq_digest` stays low.
- R10: A read granted with `mem_err` ends the run. No further read is issued and no block is presented. The count keeps the failing block's index, enable clears, and status bit 0 and `irq_error` go high.
- R11: Writing 1 to status bit 0 clears the error flag and `irq_error`. Writing 0 leaves them set.
- R12: While busy (status bit 1), writes to the address register and control writes with enable set are ignored. A control write with enable clear aborts the run once the read in flight completes, and no partial block is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| cipher_mode | input | 1 | 1 = cipher block sizes, 0 = hash, sampled at start |
| first_len_sel | input | 2 | Length of the first cipher block, sampled at start |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word address of the read |
| mem_gnt | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| mem_err | input | 1 | Bus error, valid with grant |
| blk_valid | output | 1 | Block offered to the engine |
| blk_ready | input | 1 | Engine accepts the block |
| blk_data | output | 512 | Packed block, word 0 in the low bits |
| blk_words | output | 5 | Number of meaningful words in the block |
| irq_digest | output | 1 | Hash run complete pulse |
| irq_block | output | 1 | Cipher block delivered pulse |
| irq_error | output | 1 | Sticky bus-error interrupt |

## Verification
Hash runs use a one-cycle memory latency and an engine that stalls every block, so packing order and address stepping are tested under back-pressure. Cipher runs cover all four first-block selector values with zero-latency memory and an always-ready engine. They show whether the first block's length is picked correctly and whether later blocks fall back to 4 words. An engine that holds ready low keeps a block pending, which tests hold stability and the live count readback before and after one acceptance. Error injection in the middle of the second block, and an abort during the first block, show the difference between stop-with-index and clean abandonment.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_PRESENT = 2'd2
  } hcf_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_CNT_LSB  = 16;
  localparam int unsigned STAT_ERR_BIT  = 0;
  localparam int unsigned STAT_BUSY_BIT = 1;
endpackage

// File: rtl/hcf_regs.sv
module hcf_regs
  import hcf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              adv,
  input  logic              dec,
  input  logic              stop,
  input  logic              err_set,
  output logic              start,
  output logic              en,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr,
  output logic              err
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic             ctrl_wr, addr_wr, stat_wr;
  logic [CNT_W-1:0] wcnt;
  logic             wen;

  assign ctrl_wr = wr && (sel == SEL_CTRL);
  assign addr_wr = wr && (sel == SEL_ADDR);
  assign stat_wr = wr && (sel == SEL_STAT);
  assign wcnt    = wdata[CTRL_CNT_LSB +: CNT_W];
  assign wen     = wdata[CTRL_EN_BIT];
  assign start   = ctrl_wr && !busy && wen && (wcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
    end else begin
      if (ctrl_wr && !busy) begin
        en  <= wen;
        cnt <= wcnt;
      end else begin
        if (ctrl_wr && !wen) en <= 1'b0;
        if (stop)            en <= 1'b0;
        if (dec)             cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr <= '0;
    else if (addr_wr && !busy) addr <= {wdata[ADDR_W-1:2], 2'b00};
    else if (adv)              addr <= addr + WORD_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             err <= 1'b0;
    else if (err_set)                       err <= 1'b1;
    else if (stat_wr && wdata[STAT_ERR_BIT]) err <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata[CTRL_EN_BIT]             = en;
        rdata[CTRL_CNT_LSB +: CNT_W]   = cnt;
      end
      SEL_ADDR: rdata[ADDR_W-1:0] = addr;
      SEL_STAT: begin
        rdata[STAT_ERR_BIT]  = err;
        rdata[STAT_BUSY_BIT] = busy;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/hcf_seq.sv
module hcf_seq
  import hcf_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int HASH_WORDS = 16,
  parameter int CIPH_WORDS = 4,
  parameter int NW_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cipher_mode,
  input  logic [1:0]       first_sel,
  input  logic             mem_gnt,
  input  logic             mem_err,
  input  logic             blk_ready,
  output logic             mem_req,
  output logic             blk_valid,
  output logic             busy,
  output logic             cap,
  output logic [NW_W-1:0]  idx,
  output logic [NW_W-1:0]  nwords,
  output logic             adv,
  output logic             dec,
  output logic             stop,
  output logic             err_set,
  output logic             irq_block,
  output logic             irq_digest
);
  hcf_state_e      state;
  logic [NW_W-1:0] idx_q, nw_q;
  logic            mode_q;
  logic            last_word, handshake, last_blk;

  function automatic logic [NW_W-1:0] first_len(input logic cm, input logic [1:0] s);
    if (!cm)            return NW_W'(HASH_WORDS);
    else if (s >= 2'd2) return NW_W'(3 * CIPH_WORDS);
    else                return NW_W'((int'(s) + 1) * CIPH_WORDS);
  endfunction

  assign last_word = (idx_q == nw_q - 1'b1);
  assign handshake = (state == ST_PRESENT) && blk_ready;
  assign last_blk  = (cnt == CNT_W'(1));

  always_comb begin
    mem_req   = (state == ST_FETCH);
    blk_valid = (state == ST_PRESENT);
    busy      = (state != ST_IDLE);
    cap       = mem_req && mem_gnt && !mem_err;
    adv       = cap;
    err_set   = mem_req && mem_gnt && mem_err;
    dec       = handshake;
    stop      = err_set || (handshake && last_blk);
  end

  assign idx    = idx_q;
  assign nwords = nw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx_q      <= '0;
      nw_q       <= '0;
      mode_q     <= 1'b0;
      irq_block  <= 1'b0;
      irq_digest <= 1'b0;
    end else begin
      irq_block  <= handshake && mode_q;
      irq_digest <= handshake && !mode_q && last_blk;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_FETCH;
            idx_q  <= '0;
            mode_q <= cipher_mode;
            nw_q   <= first_len(cipher_mode, first_sel);
          end
        end
        ST_FETCH: begin
          if (mem_gnt) begin
            if (mem_err || !en) state <= ST_IDLE;
            else if (last_word) state <= ST_PRESENT;
            else                idx_q <= idx_q + 1'b1;
          end
        end
        ST_PRESENT: begin
          if (blk_ready) begin
            if (last_blk || !en) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_FETCH;
              idx_q <= '0;
              nw_q  <= mode_q ? NW_W'(CIPH_WORDS) : NW_W'(HASH_WORDS);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hcf_pack.sv
module hcf_pack #(
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 16,
  parameter int NW_W      = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap,
  input  logic [NW_W-1:0]             idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W*MAX_WORDS-1:0] data
);
  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           data[g*DATA_W +: DATA_W] <= '0;
      else if (cap && idx == NW_W'(g))      data[g*DATA_W +: DATA_W] <= wdata;
    end
  end
endmodule

// File: rtl/hcf_fetch_master.sv
module hcf_fetch_master #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 11,
  parameter int HASH_WORDS = 16,
  parameter int CIPH_WORDS = 4,
  localparam int NW_W      = $clog2(HASH_WORDS + 1),
  localparam int BLK_W     = DATA_W * HASH_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cipher_mode,
  input  logic [1:0]        first_len_sel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [BLK_W-1:0]  blk_data,
  output logic [NW_W-1:0]   blk_words,
  output logic              irq_digest,
  output logic              irq_block,
  output logic              irq_error
);
  logic             busy, start, en_q, err_q;
  logic [CNT_W-1:0] cnt_q;
  logic             adv, dec, stop, err_set, cap;
  logic [NW_W-1:0]  idx;

  hcf_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .adv(adv), .dec(dec), .stop(stop),
    .err_set(err_set), .start(start), .en(en_q), .cnt(cnt_q), .addr(mem_addr),
    .err(err_q)
  );

  hcf_seq #(.CNT_W(CNT_W), .HASH_WORDS(HASH_WORDS), .CIPH_WORDS(CIPH_WORDS), .NW_W(NW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en_q), .cnt(cnt_q),
    .cipher_mode(cipher_mode), .first_sel(first_len_sel), .mem_gnt(mem_gnt),
    .mem_err(mem_err), .blk_ready(blk_ready), .mem_req(mem_req),
    .blk_valid(blk_valid), .busy(busy), .cap(cap), .idx(idx), .nwords(blk_words),
    .adv(adv), .dec(dec), .stop(stop), .err_set(err_set),
    .irq_block(irq_block), .irq_digest(irq_digest)
  );

  hcf_pack #(.DATA_W(DATA_W), .MAX_WORDS(HASH_WORDS), .NW_W(NW_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .cap(cap), .idx(idx), .wdata(mem_rdata), .data(blk_data)
  );

  assign irq_error = err_q;
endmodule

// File: rtl/hcf_fetch_master_chk.sv
module hcf_fetch_master_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 11,
  parameter int BLK_W  = 512,
  parameter int NW_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt,
  input logic              mem_err,
  input logic              blk_valid,
  input logic              blk_ready,
  input logic [BLK_W-1:0]  blk_data,
  input logic [NW_W-1:0]   blk_words,
  input logic              irq_digest,
  input logic              irq_block,
  input logic              irq_error
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !blk_valid); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && !mem_err |=> mem_addr == $past(mem_addr) + ADDR_W'(4)); // R3

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_words)); // R6

  AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !mem_req); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R7

  AST_DIGEST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_digest |-> cnt == '0 && !busy); // R8

  AST_BLOCK_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_block |-> $past(blk_valid && blk_ready)); // R9

  AST_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && mem_err |=> !mem_req && !blk_valid && cnt == $past(cnt) && irq_error); // R10
endmodule

bind hcf_fetch_master hcf_fetch_master_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_W(BLK_W), .NW_W(NW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt_q), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_err(mem_err),
  .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
  .blk_words(blk_words), .irq_digest(irq_digest), .irq_block(irq_block),
  .irq_error(irq_error)
);

// File: tb/hcf_fetch_master_tb.sv
module hcf_fetch_master_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [1:0]   reg_sel = 2'd0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         cipher_mode = 1'b0;
  logic [1:0]   first_len_sel = 2'd0;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_gnt = 1'b0;
  logic [31:0]  mem_rdata = '0;
  logic         mem_err = 1'b0;
  logic         blk_valid;
  logic         blk_ready = 1'b0;
  logic [511:0] blk_data;
  logic [4:0]   blk_words;
  logic         irq_digest, irq_block, irq_error;

  always #5 clk = ~clk;

  hcf_fetch_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cipher_mode(cipher_mode),
    .first_len_sel(first_len_sel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .blk_words(blk_words), .irq_digest(irq_digest), .irq_block(irq_block),
    .irq_error(irq_error)
  );

  int n_chk = 0, n_err = 0;
  int lat = 0, wc = 0, stall = 0, ready_mode = 0;
  bit ready_man = 0, err_on = 0;
  logic [31:0] err_addr = '0, exp_addr = '0;
  int n_reads, nblk, n_vcyc, n_req_valid, n_dig, n_bpulse;
  logic [511:0] got_dat [8];
  int got_nw [8];

  function automatic logic [31:0] wfun(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory, engine and monitor model, acting between clock edges
  always @(negedge clk) begin
    #1;
    if (mem_req && wc >= lat) begin
      mem_gnt = 1'b1; mem_rdata = wfun(mem_addr);
      mem_err = err_on && (mem_addr == err_addr); wc = 0;
    end else begin
      mem_gnt = 1'b0; mem_err = 1'b0;
      if (mem_req) wc++; else wc = 0;
    end
    case (ready_mode)
      0:       blk_ready = 1'b1;
      1:       blk_ready = (stall >= 2);
      default: blk_ready = ready_man;
    endcase
    if (blk_valid && blk_ready) stall = 0;
    else if (blk_valid)         stall++;
    if (mem_req && mem_gnt) begin
      chk("R3 read address", mem_addr, exp_addr);
      exp_addr += 4; n_reads++;
    end
    if (blk_valid && blk_ready && nblk < 8) begin
      got_dat[nblk] = blk_data; got_nw[nblk] = blk_words; nblk++;
    end
    if (blk_valid) n_vcyc++;
    if (blk_valid && mem_req) n_req_valid++;
    if (irq_digest) n_dig++;
    if (irq_block) n_bpulse++;
  end

  task automatic clear_stats();
    n_reads = 0; nblk = 0; n_vcyc = 0; n_req_valid = 0; n_dig = 0; n_bpulse = 0;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #2; d = reg_rdata;
  endtask

  task automatic wait_idle(input int max);
    logic [31:0] v;
    for (int i = 0; i < max; i++) begin
      reg_read(2'd2, v);
      if (!v[1]) return;
    end
    chk("busy timeout", 1, 0);
  endtask

  function automatic logic [31:0] ctrl_word(input int cnt, input bit en);
    return (32'(cnt) << 16) | 32'(en);
  endfunction

  task automatic chk_blocks(input string req, input logic [31:0] start, input int nexp,
                            input int first_nw, input int rest_nw);
    logic [31:0] base = start;
    chk({req, " block count"}, nblk, nexp);
    for (int b = 0; b < nexp && b < nblk; b++) begin
      int nw = (b == 0) ? first_nw : rest_nw;
      int bad = 0;
      chk({req, " block words"}, got_nw[b], nw);
      for (int k = 0; k < nw; k++)
        if (got_dat[b][32*k +: 32] !== wfun(base + 32'(4*k))) bad++;
      chk({req, " word packing mismatches"}, bad, 0);
      base += 32'(4*nw);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(2'd0, v); chk("R1 control reset", v, 0);
    reg_read(2'd1, v); chk("R1 address reset", v, 0);
    reg_read(2'd2, v); chk("R1 status reset", v, 0);
    chk("R1 outputs quiet", {mem_req, blk_valid, irq_digest, irq_block, irq_error}, 0);
  endtask

  task automatic t_no_start();
    logic [31:0] v;
    clear_stats();
    reg_write(2'd0, ctrl_word(0, 1));
    repeat (8) @(negedge clk);
    chk("R2 count 0 issues no read", n_reads, 0);
    reg_read(2'd0, v); chk("R2 control stored", v, 1);
    reg_write(2'd0, ctrl_word(5, 0));
    repeat (8) @(negedge clk);
    chk("R2 enable clear issues no read", n_reads, 0);
    reg_read(2'd2, v); chk("R2 not busy", v[1], 0);
    reg_read(2'd0, v); chk("R2 control stored", v, 32'h0005_0000);
  endtask

  task automatic t_hash();
    logic [31:0] v;
    clear_stats();
    cipher_mode = 1'b0; lat = 1; ready_mode = 1;
    reg_write(2'd1, 32'h0000_1003);
    reg_read(2'd1, v); chk("R3 address aligned", v, 32'h1000);
    exp_addr = 32'h1000;
    reg_write(2'd0, ctrl_word(2, 1));
    wait_idle(400);
    chk_blocks("R4 hash", 32'h1000, 2, 16, 16);
    chk("R4 hash reads", n_reads, 32);
    chk("R8 digest pulses", n_dig, 1);
    chk("R8 no block pulses", n_bpulse, 0);
    reg_read(2'd0, v); chk("R7 count and enable end at 0", v, 0);
    reg_read(2'd1, v); chk("R3 final address", v, 32'h1080);
  endtask

  task automatic t_cipher(input int sel);
    logic [31:0] v, start;
    int fw;
    clear_stats();
    start = 32'h4000 + 32'(sel * 256);
    fw = 4 * ((sel >= 2 ? 2 : sel) + 1);
    cipher_mode = 1'b1; first_len_sel = 2'(sel); lat = 0; ready_mode = 0;
    reg_write(2'd1, start); exp_addr = start;
    reg_write(2'd0, ctrl_word(3, 1));
    wait_idle(200);
    chk_blocks("R5 cipher", start, 3, fw, 4);
    chk("R9 block pulses", n_bpulse, 3);
    chk("R9 no digest pulse", n_dig, 0);
    reg_read(2'd0, v); chk("R7 cipher count ends 0", v, 0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    logic [511:0] snap;
    int t;
    clear_stats();
    cipher_mode = 1'b0; lat = 2; ready_mode = 2; ready_man = 1'b0;
    reg_write(2'd1, 32'h6000); exp_addr = 32'h6000;
    reg_write(2'd0, ctrl_word(2, 1));
    t = 0;
    while (!blk_valid && t < 200) begin @(negedge clk); t++; end
    snap = blk_data;
    repeat (6) @(negedge clk);
    chk("R6 valid held", blk_valid, 1);
    chk("R6 data stable", (blk_data === snap), 1);
    chk("R6 no read while valid", n_req_valid, 0);
    reg_read(2'd0, v); chk("R7 count before accept", v[26:16], 2);
    @(negedge clk); ready_man = 1'b1;
    @(negedge clk); ready_man = 1'b0;
    reg_read(2'd0, v); chk("R7 live count after accept", v[26:16], 1);
    ready_mode = 0;
    wait_idle(300);
    chk_blocks("R6 hold", 32'h6000, 2, 16, 16);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int r;
    clear_stats();
    cipher_mode = 1'b0; lat = 0; ready_mode = 0;
    err_on = 1'b1; err_addr = 32'h2000 + 32'd84;
    reg_write(2'd1, 32'h2000); exp_addr = 32'h2000;
    reg_write(2'd0, ctrl_word(3, 1));
    wait_idle(200);
    r = n_reads;
    repeat (10) @(negedge clk);
    chk("R10 reads up to failure", r, 22);
    chk("R10 no read after error", n_reads, 22);
    chk("R10 blocks before failure", nblk, 1);
    reg_read(2'd0, v);
    chk("R10 count holds failing index", v[26:16], 2);
    chk("R10 enable cleared", v[0], 0);
    reg_read(2'd2, v); chk("R10 error flag", v[0], 1);
    chk("R10 error interrupt", irq_error, 1);
    err_on = 1'b0;
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, v); chk("R11 write 0 keeps flag", v[0], 1);
    reg_write(2'd2, 32'h1);
    reg_read(2'd2, v); chk("R11 write 1 clears flag", v[0], 0);
    chk("R11 interrupt cleared", irq_error, 0);
  endtask

  task automatic t_busy_write();
    logic [31:0] v;
    int r_abort;
    clear_stats();
    cipher_mode = 1'b0; lat = 3; ready_mode = 2; ready_man = 1'b0;
    reg_write(2'd1, 32'h8000); exp_addr = 32'h8000;
    reg_write(2'd0, ctrl_word(3, 1));
    repeat (3) @(negedge clk);
    reg_write(2'd1, 32'h9000);
    reg_write(2'd0, ctrl_word(7, 1));
    reg_read(2'd0, v); chk("R12 busy control write ignored", v[26:16], 3);
    reg_write(2'd0, ctrl_word(3, 0));
    r_abort = n_reads;
    wait_idle(50);
    repeat (5) @(negedge clk);
    chk("R12 no partial block presented", n_vcyc, 0);
    chk("R12 at most the in-flight read completes", (n_reads <= r_abort + 1), 1);
    reg_read(2'd0, v); chk("R12 count unchanged by abort", v, 32'h0003_0000);
    reg_read(2'd1, v); chk("R12 busy address write ignored", v, 32'h8000 + 32'(4 * n_reads));
    ready_mode = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_start();
    t_hash();
    for (int s = 0; s < 4; s++) t_cipher(s);
    t_hold();
    t_error();
    t_busy_write();
    finish_run();
  end
endmodule